// File: doc/BRIEF.md
# AES-256 Round-Key Generator (Streaming)

This block turns a 256-bit cipher key into the fifteen 128-bit round keys of AES-256 and hands them out in ascending order, one per clock, exactly when a round datapath needs them. It never stores the full 60-word schedule. It keeps an eight-word window of the most recent schedule words and derives the next four words from that window in a single cycle.

A one-cycle `start` pulse captures `key_in`. On the following cycle round key 0 appears with `rk_valid` high and `rk_round` equal to 0. Rounds 1 to 14 follow on consecutive cycles, and `rk_valid` falls after round 14. A new `start` is accepted in any cycle, including partway through a sequence, and it restarts the schedule from the new key. The substitution box needed by the schedule is computed in logic, using the field inverse followed by the affine map, inside the block.

Top module: `aes256_key_expander`

## Requirements
- R1: While reset is applied and after it is released with no `start`, `rk_valid` is 0 and `rk_round` and `rk_data` are 0.
- R2: In the cycle after `start` is sampled high, `rk_valid` is 1, `rk_round` is 0 and `rk_data` equals `key_in[255:128]` as sampled with `start`.
- R3: One cycle after round 0, `rk_round` is 1 and `rk_data` equals the low half `key_in[127:0]` of the loaded key.
- R4: Rounds 2 to 14 appear on consecutive cycles with `rk_round` rising by one each cycle. Schedule word w(j) is bits [255-32j -: 32] of the key for j<8, `rk_data` of round r is {w(4r), w(4r+1), w(4r+2), w(4r+3)} with w(4r) in bits [127:96], and every later word is w(j) = w(j-8) XOR t(j), where t(j) = w(j-1) unless R5 or R6 applies.
- R5: For j a multiple of 8, t(j) = SubWord(RotWord(w(j-1))) XOR Rcon. RotWord moves byte [31:24] to [7:0] and shifts the other bytes up by one byte. SubWord applies the AES S-box to each byte. Rcon has 2^(j/8-1) in bits [31:24] and zeros elsewhere.
- R6: For j mod 8 equal to 4, t(j) = SubWord(w(j-1)), with no rotation and no Rcon.
- R7: In the cycle after round 14 is shown, `rk_valid` is 0, and it stays 0 until the next `start`.
- R8: A `start` sampled while a sequence is running abandons it: the next cycle shows round 0 of the new key, and the full 15-round sequence of the new key follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Load `key_in` and restart the schedule |
| key_in | input | 256 | Cipher key, first schedule word in the top bits |
| rk_valid | output | 1 | Round key on `rk_data` is valid |
| rk_round | output | 4 | Index of the round key shown, 0 to 14 |
| rk_data | output | 128 | Current round key |

## Verification
The bench compares every round of several keys against a schedule model built from its own S-box generator, and checks a fixed table of known AES-256 schedule words. A design that swapped the rotated and unrotated substitution steps, or got the Rcon progression wrong, would corrupt every round key from round 2 onwards. A design that reversed word or byte order would already fail on rounds 0 and 1. The bench also restarts the schedule at round 5 and watches the cycles after round 14: a design that carried window state across a restart would emit a mixed schedule, and one whose valid flag was left high would show a sixteenth key.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

  typedef logic [31:0] word_t;

  // multiply two field elements modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // a^254 is the multiplicative inverse (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_byte(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  // round constant for word index 8*half
  function automatic logic [7:0] rcon_byte(input logic [3:0] half);
    return 8'h01 << (half - 4'd1);
  endfunction

endpackage

// File: rtl/aes_ks_sbox.sv
module aes_ks_sbox (
  input  logic [7:0] in_b,
  output logic [7:0] out_b
);
  import aes_ks_pkg::*;

  always_comb begin
    out_b = sbox_byte(in_b);
  end

endmodule

// File: rtl/aes_ks_subword.sv
module aes_ks_subword #(
  parameter int WORD_W = 32,
  parameter int BYTES  = WORD_W / 8
) (
  input  logic [WORD_W-1:0] in_w,
  input  logic              rot_en,
  input  logic [7:0]        rcon,
  output logic [WORD_W-1:0] out_w
);
  logic [WORD_W-1:0] pre_w;
  logic [WORD_W-1:0] sub_w;

  always_comb begin
    pre_w = rot_en ? {in_w[WORD_W-9:0], in_w[WORD_W-1 -: 8]} : in_w;
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_sb
    aes_ks_sbox u_sb (
      .in_b  (pre_w[8*g +: 8]),
      .out_b (sub_w[8*g +: 8])
    );
  end

  always_comb begin
    out_w = sub_w ^ {(rot_en ? rcon : 8'h00), {(WORD_W-8){1'b0}}};
  end

endmodule

// File: rtl/aes_ks_round.sv
module aes_ks_round #(
  parameter int WORD_W = 32,
  parameter int NK     = 8,
  localparam int WIN_W = NK * WORD_W,
  localparam int RK_W  = 4 * WORD_W
) (
  input  logic [WIN_W-1:0] win,
  input  logic             even_rnd,
  input  logic [7:0]       rcon,
  output logic [RK_W-1:0]  new_words
);
  logic [WORD_W-1:0] temp_w;
  logic [WORD_W-1:0] nw [4];

  aes_ks_subword #(.WORD_W(WORD_W)) u_sub (
    .in_w   (win[WORD_W-1:0]),
    .rot_en (even_rnd),
    .rcon   (rcon),
    .out_w  (temp_w)
  );

  always_comb begin
    nw[0] = win[WIN_W-1 -: WORD_W] ^ temp_w;
    for (int i = 1; i < 4; i++) begin
      nw[i] = win[WIN_W-1-i*WORD_W -: WORD_W] ^ nw[i-1];
    end
    new_words = {nw[0], nw[1], nw[2], nw[3]};
  end

  // low half of the window is not used by the next four words
  logic unused_low;
  always_comb unused_low = ^win[WIN_W-4*WORD_W-1:WORD_W];

endmodule

// File: rtl/aes256_key_expander.sv
module aes256_key_expander #(
  parameter int WORD_W = 32,
  parameter int NK     = 8,
  parameter int NR     = 14,
  localparam int KEY_W = NK * WORD_W,
  localparam int RK_W  = 4 * WORD_W,
  localparam int RND_W = $clog2(NR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] key_in,
  output logic             rk_valid,
  output logic [RND_W-1:0] rk_round,
  output logic [RK_W-1:0]  rk_data
);
  import aes_ks_pkg::*;

  // reset synchronizer: asserts at once, releases on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [KEY_W-1:0] win_q, win_d;
  logic [RK_W-1:0]  rk_q, rk_d;
  logic [RND_W-1:0] rnd_q, rnd_d, rnd_nx;
  logic             val_q, val_d;
  logic             upd_en;
  logic [RK_W-1:0]  new_words;
  logic [3:0]       rcon_half;
  logic [7:0]       rcon;

  always_comb begin
    rnd_nx    = rnd_q + 1'b1;
    rcon_half = 4'(rnd_nx >> 1);
    rcon      = rcon_byte(rcon_half);
  end

  aes_ks_round #(.WORD_W(WORD_W), .NK(NK)) u_round (
    .win       (win_q),
    .even_rnd  (~rnd_nx[0]),
    .rcon      (rcon),
    .new_words (new_words)
  );

  // next-state
  always_comb begin
    win_d  = win_q;
    rk_d   = rk_q;
    rnd_d  = rnd_q;
    val_d  = val_q;
    upd_en = 1'b0;
    if (start) begin
      upd_en = 1'b1;
      win_d  = key_in;
      rk_d   = key_in[KEY_W-1 -: RK_W];
      rnd_d  = '0;
      val_d  = 1'b1;
    end else if (val_q) begin
      upd_en = 1'b1;
      if (rnd_q == RND_W'(NR)) begin
        val_d = 1'b0;
      end else if (rnd_q == '0) begin
        rk_d  = win_q[RK_W-1:0];
        rnd_d = rnd_nx;
      end else begin
        rk_d  = new_words;
        win_d = {win_q[KEY_W-RK_W-1:0], new_words};
        rnd_d = rnd_nx;
      end
    end
  end

  // registers with explicit enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      win_q <= '0;
      rk_q  <= '0;
      rnd_q <= '0;
      val_q <= 1'b0;
    end else if (upd_en) begin
      win_q <= win_d;
      rk_q  <= rk_d;
      rnd_q <= rnd_d;
      val_q <= val_d;
    end
  end

  assign rk_valid = val_q;
  assign rk_round = rnd_q;
  assign rk_data  = rk_q;

  // R2 / R8: a start always loads round 0 from the key top half
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> (rk_valid && rk_round == '0 && rk_data == $past(key_in[KEY_W-1 -: RK_W])));

  // R3: round 1 is the lower half of the captured key
  a_r3_second_half: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rk_valid && rk_round == '0 && !start) |=> (rk_round == 1 && rk_data == $past(win_q[RK_W-1:0])));

  // R4: the round index steps by one while the sequence runs
  a_r4_round_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rk_valid && rk_round != RND_W'(NR) && !start) |=>
      (rk_valid && rk_round == RND_W'($past(rk_round) + 1'b1)));

  // R7: valid ends after the last round
  a_r7_valid_ends: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rk_valid && rk_round == RND_W'(NR) && !start) |=> !rk_valid);

  // R7: idle stays idle without a start
  a_r7_idle_stays: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rk_valid && !start) |=> !rk_valid);

endmodule

// File: tb/aes256_key_expander_tb.sv
`timescale 1ns/1ps
module aes256_key_expander_tb;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [255:0] key_in;
  logic         rk_valid;
  logic [3:0]   rk_round;
  logic [127:0] rk_data;

  aes256_key_expander u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .key_in   (key_in),
    .rk_valid (rk_valid),
    .rk_round (rk_round),
    .rk_data  (rk_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0]   tb_sbox [256];
  logic [31:0]  mw [60];
  logic [127:0] exp_rk [15];
  logic [127:0] got_rk [15];
  logic [3:0]   got_rn [15];
  logic         got_v  [15];

  // known schedule values: {round, round key}
  localparam logic [255:0] KEY_A = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
  localparam logic [131:0] VEC [5] = '{
    {4'd0,  128'h603deb1015ca71be2b73aef0857d7781},
    {4'd1,  128'h1f352c073b6108d72d9810a30914dff4},
    {4'd2,  128'h9ba354118e6925afa51a8b5f2067fcde},
    {4'd3,  128'ha8b09c1a93d194cdbe49846eb75d5b9a},
    {4'd14, 128'hfe4890d1e6188d0b046df344706c631e}
  };

  function automatic logic [7:0] rl(input logic [7:0] v, input int s);
    return (v << s) | (v >> (8 - s));
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q, pn;
    p = 8'h01; q = 8'h01;
    do begin
      pn = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      p  = pn;
      q  = q ^ {q[6:0], 1'b0};
      q  = q ^ {q[5:0], 2'b00};
      q  = q ^ {q[3:0], 4'b0000};
      if (q[7]) q = q ^ 8'h09;
      tb_sbox[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    tb_sbox[0] = 8'h63;
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {tb_sbox[w[31:24]], tb_sbox[w[23:16]], tb_sbox[w[15:8]], tb_sbox[w[7:0]]};
  endfunction

  task automatic model(input logic [255:0] k);
    logic [31:0] t;
    for (int i = 0; i < 8; i++) mw[i] = k[255-32*i -: 32];
    for (int i = 8; i < 60; i++) begin
      t = mw[i-1];
      if (i % 8 == 0)      t = subw({t[23:0], t[31:24]}) ^ {8'(8'h01 << (i/8 - 1)), 24'h0};
      else if (i % 8 == 4) t = subw(t);
      mw[i] = mw[i-8] ^ t;
    end
    for (int r = 0; r < 15; r++) exp_rk[r] = {mw[4*r], mw[4*r+1], mw[4*r+2], mw[4*r+3]};
  endtask

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // start at a negedge, then record 15 consecutive cycles at negedges
  task automatic run_seq(input logic [255:0] k);
    @(negedge clk);
    start = 1'b1; key_in = k;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      start = 1'b0; key_in = ~k;
      got_rk[c] = rk_data; got_rn[c] = rk_round; got_v[c] = rk_valid;
    end
  endtask

  task automatic check_all(input string tag);
    for (int r = 0; r < 15; r++) begin
      string req;
      if (r == 0)          req = "R2";
      else if (r == 1)     req = "R3";
      else if (r % 2 == 0) req = "R5";
      else                 req = "R6";
      chk($sformatf("%s %s data round %0d", req, tag, r), got_rk[r], exp_rk[r]);
      chk($sformatf("R4 %s index/valid round %0d", tag, r), {123'h0, got_v[r], got_rn[r]}, {123'h0, 1'b1, 4'(r)});
    end
  endtask

  task automatic check_tail();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R7 valid low after round 14", {127'h0, rk_valid}, 128'h0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; key_in = '0;
    build_sbox();
    chk("R5 sbox model 00", {120'h0, tb_sbox[8'h00]}, {120'h0, 8'h63});
    chk("R5 sbox model 53", {120'h0, tb_sbox[8'h53]}, {120'h0, 8'hed});
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {127'h0, rk_valid}, 128'h0);
    chk("R1 reset outputs", rk_data | {124'h0, rk_round}, 128'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {123'h0, rk_valid, rk_round} | rk_data, 128'h0);

    // known-value table walk
    run_seq(KEY_A);
    for (int v = 0; v < 5; v++) begin
      chk($sformatf("R4 table round %0d", int'(VEC[v][131:128])), got_rk[VEC[v][131:128]], VEC[v][127:0]);
    end
    check_tail();

    // model comparison on several keys
    model(KEY_A);   check_all("keyA");
    run_seq(256'h0); model(256'h0); check_all("zero"); check_tail();
    run_seq({256{1'b1}}); model({256{1'b1}}); check_all("ones"); check_tail();
    run_seq(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f);
    model(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f);
    check_all("seq"); check_tail();

    // restart mid-sequence at round 5
    @(negedge clk);
    start = 1'b1; key_in = 256'h0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      start = 1'b0;
    end
    chk("R8 running before restart", {123'h0, rk_valid, rk_round}, {123'h0, 1'b1, 4'd5});
    start = 1'b1; key_in = KEY_A;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      start = 1'b0; key_in = '0;
      got_rk[c] = rk_data; got_rn[c] = rk_round; got_v[c] = rk_valid;
    end
    model(KEY_A);
    check_all("R8 restart");
    check_tail();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule